// File: doc/BRIEF.md
# General-Purpose Pin Bank with Direction and Output Control

This block is the register side of a sixteen-pin general-purpose I/O port. A processor reaches it over a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. Each pin has a direction bit that decides whether the pad driver is switched on, and an output latch bit that gives the level it drives. The output latch can be loaded as a whole word. It can also be changed one bit at a time through two alias offsets: one sets the bits written as 1 and the other clears them. Other bits are left as they were, so software needs no read-modify-write.

Pins come back from the pads through a two-flop synchronizer that runs on the peripheral clock. The synchronized levels can be read at their own offset. The pad outputs are a driver enable and a drive value per pin, and they go straight to the pad ring. Pad multiplexing and the tri-state cells sit outside the block.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset every direction bit is 1 (all pins inputs), the output latch is all zeros, and every pad driver enable is 0.
- R2: Direction bit n (offset 0x10, bits 15..0) selects output when 0 and input when 1. The pad driver enable for pin n is the inverse of that bit and follows a write on the next clock edge.
- R3: The pad drive value for pin n equals output latch bit n.
- R4: A write to offset 0x14 loads bits 15..0 of the write data into the output latch, and a read of 0x14 returns the latch.
- R5: A write to offset 0x18 sets each latch bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: A write to offset 0x1C clears each latch bit whose write-data bit is 1. Bits written as 0 keep their value.
- R7: Reads of offsets 0x18 and 0x1C return the output latch contents, not the pin levels.
- R8: Bits 31..16 of every register read as 0, and write data in those bits has no effect.
- R9: A read of offset 0x20 returns the pin levels after two register stages. A level change on a pin becomes visible after the second rising clock edge and not after the first.
- R10: For a pin configured as input, writes to 0x14, 0x18 or 0x1C leave its driver enable at 0 while the latch still updates. The new value is driven once the pin becomes an output.
- R11: Offsets other than 0x10, 0x14, 0x18, 0x1C and 0x20 read as 0. Writes to them, and writes to 0x20, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register being accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the current address, combinational |
| pad_in | input | NUM_PINS (16) | Asynchronous pin levels from the pads |
| pad_oe | output | NUM_PINS (16) | Per-pin driver enable, 1 drives the pad |
| pad_out | output | NUM_PINS (16) | Per-pin drive value |

## Verification
The bench builds the block with its default parameters: sixteen pins on a 32-bit bus with an 8-bit offset. This leaves a sixteen-bit reserved upper half on every register, where write data carrying ones can be shown to vanish on read-back. The 8-bit offset space also contains unmapped offsets on both sides of the register window (0x00 and 0x24), so the bench can read those and write to them. Mixed direction words put input pins and output pins side by side, so alias writes aimed at input pins can be seen to update the latch without enabling a driver.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register offsets; software and the address decoder depend on these.
    localparam int unsigned OFS_DIR   = 32'h10;
    localparam int unsigned OFS_OUT   = 32'h14;
    localparam int unsigned OFS_SET   = 32'h18;
    localparam int unsigned OFS_CLR   = 32'h1C;
    localparam int unsigned OFS_IN    = 32'h20;

    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_OUT  = 3'd2,
        SEL_SET  = 3'd3,
        SEL_CLR  = 3'd4,
        SEL_IN   = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    always_comb begin
        if      (addr == ADDR_W'(OFS_DIR)) sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_OUT)) sel = SEL_OUT;
        else if (addr == ADDR_W'(OFS_SET)) sel = SEL_SET;
        else if (addr == ADDR_W'(OFS_CLR)) sel = SEL_CLR;
        else if (addr == ADDR_W'(OFS_IN))  sel = SEL_IN;
        else                               sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_sync
);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            logic [SYNC_STAGES-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= {stage_q[SYNC_STAGES-2:0], pin_async[p]};
                end
            end
            assign pin_sync[p] = stage_q[SYNC_STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [NUM_PINS-1:0] wr_bits,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            out_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DIR: dir_q <= wr_bits;
                SEL_OUT: out_q <= wr_bits;
                SEL_SET: out_q <= out_q | wr_bits;
                SEL_CLR: out_q <= out_q & ~wr_bits;
                default: ;
            endcase
        end
    end

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_drv
            assign pad_oe[p]  = ~dir_q[p];
            assign pad_out[p] = out_q[p];
        end
    endgenerate

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32
) (
    input  reg_sel_e            sel,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] out_q,
    input  logic [NUM_PINS-1:0] in_sync,
    output logic [DATA_W-1:0]   rdata
);

    always_comb begin
        unique case (sel)
            SEL_DIR:                   rdata = DATA_W'(dir_q);
            SEL_OUT, SEL_SET, SEL_CLR: rdata = DATA_W'(out_q);
            SEL_IN:                    rdata = DATA_W'(in_sync);
            default:                   rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out
);

    reg_sel_e            sel_w;
    logic [NUM_PINS-1:0] dir_w;
    logic [NUM_PINS-1:0] out_w;
    logic [NUM_PINS-1:0] in_sync_w;
    logic                unused_hi_wdata;

    // Reserved upper write-data bits are dropped here.
    assign unused_hi_wdata = ^bus_wdata[DATA_W-1:NUM_PINS];

    gpio_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .sel  (sel_w)
    );

    gpio_ctl_regs #(.NUM_PINS(NUM_PINS)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we),
        .sel     (sel_w),
        .wr_bits (bus_wdata[NUM_PINS-1:0]),
        .dir_q   (dir_w),
        .out_q   (out_w),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pad_in),
        .pin_sync  (in_sync_w)
    );

    gpio_rd_mux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) rmux_i (
        .sel     (sel_w),
        .dir_q   (dir_w),
        .out_q   (out_w),
        .in_sync (in_sync_w),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] out_w,
    input logic [NUM_PINS-1:0] in_sync_w
);

    logic [1:0] since_rst;
    logic       mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2) since_rst <= since_rst + 2'd1;
    end

    assign mapped = (bus_addr == ADDR_W'(OFS_DIR)) || (bus_addr == ADDR_W'(OFS_OUT)) ||
                    (bus_addr == ADDR_W'(OFS_SET)) || (bus_addr == ADDR_W'(OFS_CLR)) ||
                    (bus_addr == ADDR_W'(OFS_IN));

    // R2: driver enable follows the written direction word
    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=> pad_oe == ~$past(bus_wdata[NUM_PINS-1:0]));

    // R5: set alias raises written ones, keeps the rest
    a_r5_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_SET)) |=>
            (out_w == ($past(out_w) | $past(bus_wdata[NUM_PINS-1:0]))));

    // R6: clear alias drops written ones, keeps the rest
    a_r6_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_CLR)) |=>
            (out_w == ($past(out_w) & ~$past(bus_wdata[NUM_PINS-1:0]))));

    // R8: reserved read bits stay zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PINS] == '0);

    // R11: unmapped offsets read zero and writes there leave the latch alone
    a_r11_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);
    a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> $stable(out_w));

    // R9: synchronized level lags the pin by two edges
    a_r9_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2) |-> in_sync_w == $past(pad_in, 2));

endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .out_w     (out_w),
    .in_sync_w (in_sync_w)
);

// File: tb/gpio_pin_bank_tb_top.sv
module gpio_pin_bank_tb_top;

    localparam int NP = 16;
    localparam int DW = 32;
    localparam int AW = 8;

    typedef enum int { K_RD, K_OE, K_OUT } kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    item_t sb_q[$];

    // bench-side model, written from the requirements
    logic [NP-1:0] m_dir = '1;
    logic [NP-1:0] m_out = '0;

    always #5 clk = ~clk;

    gpio_pin_bank #(.NUM_PINS(NP), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
        .pad_in, .pad_oe, .pad_out
    );

    task automatic expect_item(kind_e k, logic [AW-1:0] a, logic [31:0] e, string tag);
        item_t it;
        @(negedge clk);
        bus_we   = 0;
        bus_addr = a;
        it.kind = k; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1;
        case (a)
            8'h10: m_dir = d[NP-1:0];
            8'h14: m_out = d[NP-1:0];
            8'h18: m_out = m_out | d[NP-1:0];
            8'h1C: m_out = m_out & ~d[NP-1:0];
            default: ;
        endcase
        @(negedge clk);
        bus_we = 0;
    endtask

    // monitor: compares queued expectations away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() != 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_OE:    act = 32'(pad_oe);
                    default: act = 32'(pad_out);
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        expect_item(K_RD, 8'h10, 32'h0000_FFFF, "R1 dir reset");
        expect_item(K_RD, 8'h14, 32'h0, "R1 out reset");
        expect_item(K_OE, 8'h00, 32'h0, "R1 oe reset");

        // R2 / R8 direction with reserved bits set
        wr(8'h10, 32'hFFFF_00F0);
        expect_item(K_RD, 8'h10, 32'h0000_00F0, "R8 dir reserved");
        expect_item(K_OE, 8'h00, 32'h0000_FF0F, "R2 oe inverse");

        // R4 / R3 direct write
        wr(8'h14, 32'h1234_A5A5);
        expect_item(K_RD, 8'h14, 32'(m_out), "R4 out direct");
        expect_item(K_OUT, 8'h00, 32'(m_out), "R3 pad drive");

        // R5 / R7 set alias
        wr(8'h18, 32'hFFFF_0102);
        expect_item(K_RD, 8'h18, 32'(m_out), "R5 set ones R7 read set");
        expect_item(K_RD, 8'h1C, 32'(m_out), "R7 read clr");
        wr(8'h18, 32'h0);
        expect_item(K_RD, 8'h14, 32'(m_out), "R5 set zeros no effect");

        // R6 clear alias
        wr(8'h1C, 32'h0000_8001);
        expect_item(K_RD, 8'h14, 32'(m_out), "R6 clr ones");
        wr(8'h1C, 32'h0);
        expect_item(K_OUT, 8'h00, 32'(m_out), "R6 clr zeros no effect");

        // R10 input pins 4..7: latch updates, driver stays off
        wr(8'h1C, 32'h0000_00F0);
        wr(8'h18, 32'h0000_0050);
        expect_item(K_OE, 8'h00, 32'h0000_FF0F, "R10 oe unchanged");
        expect_item(K_RD, 8'h14, 32'(m_out), "R10 latch updated");
        wr(8'h10, 32'h0);
        expect_item(K_OE, 8'h00, 32'h0000_FFFF, "R10 all outputs");
        expect_item(K_OUT, 8'h00, 32'(m_out), "R10 latched value driven");

        // R11 unmapped offsets and input-register writes
        expect_item(K_RD, 8'h00, 32'h0, "R11 read 0x00");
        expect_item(K_RD, 8'h24, 32'h0, "R11 read 0x24");
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        expect_item(K_RD, 8'h14, 32'(m_out), "R11 out unchanged");
        expect_item(K_RD, 8'h10, 32'(m_dir), "R11 dir unchanged");

        // R9 two-stage input path
        @(negedge clk);
        pad_in = 16'hC3A5;
        expect_item(K_RD, 8'h20, 32'h0, "R9 one edge old");
        expect_item(K_RD, 8'h20, 32'h0000_C3A5, "R9 two edges new");
        @(negedge clk);
        pad_in = 16'h3C5A;
        expect_item(K_RD, 8'h20, 32'h0000_C3A5, "R9 second pattern old");
        expect_item(K_RD, 8'h20, 32'h0000_3C5A, "R9 second pattern new");

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 0;
        m_dir = '1; m_out = '0;
        @(negedge clk);
        rst_n = 1;
        expect_item(K_RD, 8'h10, 32'h0000_FFFF, "R1 dir re-reset");
        expect_item(K_OUT, 8'h00, 32'h0, "R1 out re-reset");
        expect_item(K_OE, 8'h00, 32'h0, "R1 oe re-reset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule